// File: doc/BRIEF.md
# Flash Write Status Responder

This block produces the byte a flash device returns on reads. A command decoder starts an internal program or erase with a single-cycle pulse. From that edge a busy timer runs for a fixed length that depends on the operation. While the timer runs, the block replaces array reads with a status byte. Bit 7 is a polling bit: it is the inverse of the byte being written during a program, and 0 during an erase. Bit 6 flips on each read, so host software can poll either bit until the operation ends.

The busy lengths are parameters, counted in clock cycles. They stand for the 20 µs program, 25 ms sector erase and 100 ms chip erase maxima, scaled down so that simulation stays short. A completed program is followed by a short settling window. In that window bit 7 already shows the true data but the other bits do not yet.

With identification mode selected and the upper address bits at zero, reads return the manufacturer code or the device code instead of the array byte. Read results are registered on the read strobe and hold until the next strobe.

Top module: `flash_status_responder`

## Requirements
- R1: After reset the read output is 8'h00 and no operation is busy.
- R2: An idle read outside identification returns `array_data` on the edge of `rd_stb`. Without a strobe, `rd_data` keeps its last value.
- R3: During a busy program (op 2'b00), the read byte is {~D7, T, 6'b0}. D7 is bit 7 of the data latched with the start pulse and T is the toggle bit.
- R4: During a busy sector erase (op 2'b01) or chip erase (op 2'b10), the read byte is {1'b0, T, 6'b0}. After the operation, reads return `array_data` again.
- R5: The toggle bit is cleared at launch and inverts on each busy read, so the first busy read shows 1. Edges without a read leave it unchanged.
- R6: Let the launch edge be edge 0. Reads at edges 1 through N are busy, and the read at edge N+1 is not. N is PROG_CYC for a program, SECT_CYC for a sector erase and CHIP_CYC for a chip erase.
- R7: After a program, reads at edges N+1 through N+SETTLE_CYC return {D7, T, 6'b0}, with T frozen at its final busy value. Erases have no settling window.
- R8: A start pulse while busy is ignored and does not extend or restart the operation. A start with op 2'b11 never launches.
- R9: When idle with `id_mode` high and `rd_addr[ADDR_W-1:1]` zero, a read returns MFR_CODE (8'hBF) for A0=0 and DEV_CODE for A0=1. Any other address returns `array_data`.
- R10: While busy, the status byte takes precedence over identification reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse from the command decoder |
| op_type | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 none |
| prog_data | input | 8 | Byte being programmed, latched at launch |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| id_mode | input | 1 | Identification mode active |
| array_data | input | 8 | Byte read from the array at `rd_addr` |
| rd_data | output | 8 | Registered read result |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that a read strobe and a start pulse never fall on the same edge, because the toggle relation between consecutive busy reads relies on no launch coming between them. The stimulus changes inputs only on falling clock edges and raises at most one of `rd_stb` and `start` per cycle. Every busy length parameter is at least 1, as the timer expects.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_NONE = 2'b11
    } op_e;

    localparam logic [7:0] STATUS_LOW_ZERO = 8'h00;
endpackage

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer #(
    parameter int CW = 6,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [CW-1:0] len,
    input  logic [SW-1:0] settle_len,
    output logic          busy,
    output logic          settling
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [SW-1:0] scnt;
    } tmr_t;

    localparam logic [CW-1:0] ONE_C = CW'(1);
    localparam logic [SW-1:0] ONE_S = SW'(1);

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (launch) begin
            t_d.busy = 1'b1;
            t_d.cnt  = len;
            t_d.scnt = '0;
        end else if (t_q.busy) begin
            if (t_q.cnt <= ONE_C) begin
                t_d.busy = 1'b0;
                t_d.cnt  = '0;
                t_d.scnt = settle_len;
            end else begin
                t_d.cnt = t_q.cnt - ONE_C;
            end
        end else if (t_q.scnt != '0) begin
            t_d.scnt = t_q.scnt - ONE_S;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy     = t_q.busy;
    assign settling = t_q.scnt != '0;
endmodule

// File: rtl/fsr_id_decode.sv
module fsr_id_decode #(
    parameter int         ADDR_W   = 17,
    parameter logic [7:0] MFR_CODE = 8'hBF,
    parameter logic [7:0] DEV_CODE = 8'hD6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [7:0]        code
);
    always_comb begin
        hit  = addr[ADDR_W-1:1] == '0;
        code = addr[0] ? DEV_CODE : MFR_CODE;
    end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
    import fsr_pkg::*;
#(
    parameter int         ADDR_W     = 17,
    parameter int         PROG_CYC   = 8,   // scaled stand-in for 20 us
    parameter int         SECT_CYC   = 20,  // scaled stand-in for 25 ms
    parameter int         CHIP_CYC   = 40,  // scaled stand-in for 100 ms
    parameter int         SETTLE_CYC = 4,   // scaled stand-in for 1 us
    parameter logic [7:0] MFR_CODE   = 8'hBF,
    parameter logic [7:0] DEV_CODE   = 8'hD6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_type,
    input  logic [7:0]        prog_data,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              id_mode,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data
);
    localparam int MAX_PS = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_C  = (MAX_PS > CHIP_CYC) ? MAX_PS : CHIP_CYC;
    localparam int CW     = $clog2(MAX_C + 1);
    localparam int SW     = $clog2(SETTLE_CYC + 2);

    localparam logic [CW-1:0] LEN_PROG = CW'(PROG_CYC);
    localparam logic [CW-1:0] LEN_SECT = CW'(SECT_CYC);
    localparam logic [CW-1:0] LEN_CHIP = CW'(CHIP_CYC);
    localparam logic [SW-1:0] LEN_SETL = SW'(SETTLE_CYC);

    typedef struct packed {
        logic       is_prog;
        logic       bit7;
        logic       tog;
        logic [7:0] rd;
    } st_t;

    st_t st_d, st_q;

    logic          busy_w, settling_w, launch_w, id_hit_w;
    logic [CW-1:0] len_w;
    logic [SW-1:0] settle_len_w;
    logic [7:0]    id_code_w;
    op_e           op_w;

    assign op_w     = op_e'(op_type);
    assign launch_w = start && !busy_w && (op_w != OP_NONE);

    always_comb begin
        case (op_w)
            OP_PROG: len_w = LEN_PROG;
            OP_SECT: len_w = LEN_SECT;
            default: len_w = LEN_CHIP;
        endcase
    end

    assign settle_len_w = st_q.is_prog ? LEN_SETL : '0;

    fsr_busy_timer #(.CW(CW), .SW(SW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch_w),
        .len        (len_w),
        .settle_len (settle_len_w),
        .busy       (busy_w),
        .settling   (settling_w)
    );

    fsr_id_decode #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .addr (rd_addr),
        .hit  (id_hit_w),
        .code (id_code_w)
    );

    always_comb begin
        st_d = st_q;
        if (launch_w) begin
            st_d.is_prog = op_w == OP_PROG;
            st_d.bit7    = prog_data[7];
            st_d.tog     = 1'b0;
        end
        if (rd_stb) begin
            if (busy_w) begin
                st_d.tog = ~st_q.tog;
                st_d.rd  = {st_q.is_prog & ~st_q.bit7, ~st_q.tog, STATUS_LOW_ZERO[5:0]};
            end else if (settling_w) begin
                st_d.rd  = {st_q.bit7, st_q.tog, STATUS_LOW_ZERO[5:0]};
            end else if (id_mode && id_hit_w) begin
                st_d.rd  = id_code_w;
            end else begin
                st_d.rd  = array_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       rd_stb,
    input logic       busy,
    input logic       settling,
    input logic       is_prog,
    input logic       bit7,
    input logic [7:0] rd_data
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && busy && is_prog |=> rd_data[7] == ~$past(bit7));

    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && busy && !is_prog |=> rd_data[7] == 1'b0);

    assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && busy && $past(rd_stb && busy) |=> rd_data[6] != $past(rd_data[6]));

    assert_settle_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        settling |-> !busy);

    assert_launch_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind flash_status_responder fsr_checker u_fsr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_stb   (rd_stb),
    .busy     (busy_w),
    .settling (settling_w),
    .is_prog  (st_q.is_prog),
    .bit7     (st_q.bit7),
    .rd_data  (rd_data)
);

// File: tb/tb_flash_status_responder.sv
module tb_flash_status_responder;
    localparam int         AW     = 17;
    localparam int         P_CYC  = 8;
    localparam int         S_CYC  = 20;
    localparam int         C_CYC  = 40;
    localparam int         SETL   = 4;
    localparam logic [7:0] DEVC   = 8'hD6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op_type = 2'b00;
    logic [7:0]    prog_data = 8'h00;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          id_mode = 1'b0;
    logic [7:0]    array_data = 8'h00;
    logic [7:0]    rd_data;

    int checks = 0;
    int fails  = 0;

    // model of the requirements
    int         since = 1000000;
    int         dur = 0;
    bit         m_prog = 1'b0;
    bit         m_b7 = 1'b0;
    bit         m_tog = 1'b0;
    logic [7:0] last = 8'h00;

    always #2.5 clk = ~clk;

    flash_status_responder #(
        .ADDR_W(AW), .PROG_CYC(P_CYC), .SECT_CYC(S_CYC), .CHIP_CYC(C_CYC),
        .SETTLE_CYC(SETL), .MFR_CODE(8'hBF), .DEV_CODE(DEVC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_type(op_type),
        .prog_data(prog_data), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .id_mode(id_mode), .array_data(array_data), .rd_data(rd_data)
    );

    // {id_mode, addr[16:0], array, expected}
    localparam logic [33:0] VEC [8] = '{
        {1'b0, 17'h00000, 8'h3C, 8'h3C},
        {1'b0, 17'h00001, 8'hA5, 8'hA5},
        {1'b1, 17'h00000, 8'h11, 8'hBF},
        {1'b1, 17'h00001, 8'h22, DEVC},
        {1'b1, 17'h00002, 8'h33, 8'h33},
        {1'b1, 17'h10000, 8'h44, 8'h44},
        {1'b1, 17'h10001, 8'h55, 8'h55},
        {1'b0, 17'h1FFFF, 8'hFF, 8'hFF}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected %h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    function automatic int op_len(input logic [1:0] op);
        if (op == 2'b00) return P_CYC;
        if (op == 2'b01) return S_CYC;
        return C_CYC;
    endfunction

    // one clock edge; inputs applied at the falling edge before it
    task automatic step(input bit rd, input bit st, input logic [1:0] op,
                        input logic [7:0] data, input bit idm,
                        input logic [AW-1:0] addr, input logic [7:0] arr,
                        input string tag);
        logic [7:0] exp;
        bit bz, stl;
        rd_stb = rd; start = st; op_type = op; prog_data = data;
        id_mode = idm; rd_addr = addr; array_data = arr;
        @(posedge clk); #1;
        since++;
        bz  = (since >= 1) && (since <= dur);
        stl = m_prog && (since > dur) && (since <= dur + SETL);
        if (rd) begin
            if (bz) begin
                m_tog = ~m_tog;
                exp = {m_prog & ~m_b7, m_tog, 6'b0};
            end else if (stl) begin
                exp = {m_b7, m_tog, 6'b0};
            end else if (idm && addr[AW-1:1] == '0) begin
                exp = addr[0] ? DEVC : 8'hBF;
            end else begin
                exp = arr;
            end
            last = exp;
        end
        chk(tag, rd_data, last);
        if (st && !bz && op != 2'b11) begin
            since  = 0;
            dur    = op_len(op);
            m_prog = (op == 2'b00);
            m_b7   = data[7];
            m_tog  = 1'b0;
        end
        @(negedge clk);
        rd_stb = 1'b0; start = 1'b0;
    endtask

    initial begin
        #500000;
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset value", rd_data, 8'h00);

        // table of idle reads (R2, R9)
        for (int i = 0; i < 8; i++) begin
            step(1, 0, 2'b00, 8'h00, VEC[i][33], VEC[i][32:16], VEC[i][15:8], "R9 idle/id read table");
        end
        // no strobe: output holds while array changes (R2)
        for (int i = 0; i < 3; i++) step(0, 0, 2'b00, 8'h00, 0, 17'h5, 8'h77 + 8'(i), "R2 hold");

        // program with bit7=1: busy, settle, then array (R3 R5 R6 R7)
        step(0, 1, 2'b00, 8'hA5, 0, 17'h100, 8'h00, "R6 launch program");
        for (int i = 0; i < P_CYC; i++) step(1, 0, 2'b00, 8'h00, 0, 17'h100, 8'hFF, "R3 program poll");
        for (int i = 0; i < SETL; i++)  step(1, 0, 2'b00, 8'h00, 0, 17'h100, 8'h12, "R7 settle");
        step(1, 0, 2'b00, 8'h00, 0, 17'h100, 8'h5A, "R6 program end");

        // program with bit7=0, gaps without reads, ignored start (R5 R8)
        step(0, 1, 2'b00, 8'h35, 0, 17'h200, 8'h00, "R6 launch program 2");
        step(1, 0, 2'b00, 8'h00, 0, 17'h200, 8'hC3, "R3 poll inverted zero");
        step(0, 0, 2'b00, 8'h00, 0, 17'h200, 8'hC3, "R5 no read no flip");
        step(0, 1, 2'b01, 8'h80, 0, 17'h200, 8'hC3, "R8 start while busy");
        step(1, 0, 2'b00, 8'h00, 0, 17'h200, 8'hC3, "R5 second read");
        for (int i = 0; i < 12; i++) step(1, 0, 2'b00, 8'h00, 0, 17'h200, 8'h35, "R8 length unchanged");

        // sector erase with id reads during busy (R4 R10)
        step(0, 1, 2'b01, 8'hFF, 0, 17'h300, 8'h00, "R6 launch sector");
        for (int i = 0; i < 3; i++) step(1, 0, 2'b00, 8'h00, 1, 17'h0, 8'h99, "R10 id masked");
        for (int i = 0; i < S_CYC - 1; i++) step(1, 0, 2'b00, 8'h00, 0, 17'h300, 8'hFF, "R4 sector erase");

        // chip erase run to completion (R4 R6)
        step(0, 1, 2'b10, 8'h00, 0, 17'h0, 8'h00, "R6 launch chip");
        for (int i = 0; i < C_CYC + 2; i++) step(1, 0, 2'b00, 8'h00, 0, 17'h400, 8'hF7, "R6 chip erase");

        // op 11 never launches (R8)
        step(0, 1, 2'b11, 8'h00, 0, 17'h0, 8'h00, "R8 null op");
        step(1, 0, 2'b00, 8'h00, 0, 17'h40, 8'h6B, "R8 null op read");
        step(1, 0, 2'b00, 8'h00, 1, 17'h1, 8'h6B, "R9 id after ops");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule